// File: doc/BRIEF.md
# Cascadable Display Memory Loader

This block receives a stream of 4-bit display nibbles from a serial-bus front end and stores them in an 80-entry display memory. A data pointer picks the entry that the next nibble goes to. The pointer steps forward by itself after every nibble, so the host sends only an address and then plain data.

Several of these devices can share one bus in a cascade. Each device holds a 3-bit device counter and compares it with its own strapped 3-bit identity pins. Only a device whose counter matches its pins stores nibbles. Every device still advances its pointer and counter on every nibble, matched or not. When the pointer passes the last entry, it returns to zero and the device counter steps on. One unbroken data stream therefore fills device after device.

Two commands set the position directly: a pointer load and a device-counter load. A read port gives combinational access to the memory for the display sequencer.

Top module: `disp_ram_writer`

## Requirements
- R1: After reset the pointer is 0, the device counter is 0 and every memory entry reads 0.
- R2: A nibble accepted while the device counter equals `dev_id_i` is stored at the entry named by the pointer, and the pointer then increments by one.
- R3: A nibble accepted while the pointer is 79 moves the pointer to 0 and increments the device counter modulo 8, so 7 is followed by 0.
- R4: A nibble accepted while the device counter differs from `dev_id_i` changes no memory entry, but the pointer and the device counter advance exactly as in R2 and R3.
- R5: The pointer always lies in the range 0 to 79.
- R6: A pointer load sets the pointer to `ptr_val_i` when that value is 79 or less, and to 0 when it is 80 or more.
- R7: A device-counter load sets the counter to `dev_val_i`.
- R8: A nibble presented in the same cycle as either load is dropped: it is not stored and does not advance the pointer. Both loads may act in one cycle.
- R9: `rd_data_o` shows the entry addressed by `rd_addr_i` in the same cycle, and shows 0 for any address of 80 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_id_i | input | 3 | Strapped device identity |
| wr_valid_i | input | 1 | Nibble strobe, one nibble per cycle |
| wr_data_i | input | 4 | Nibble value |
| ld_ptr_i | input | 1 | Pointer load command |
| ptr_val_i | input | 7 | Pointer load value |
| ld_dev_i | input | 1 | Device-counter load command |
| dev_val_i | input | 3 | Device-counter load value |
| rd_addr_i | input | 7 | Read address |
| rd_data_o | output | 4 | Read data |
| ptr_o | output | 7 | Current data pointer |
| dev_cnt_o | output | 3 | Current device counter |

## Verification
A full 80-nibble stream, with values derived arithmetically from the address, fills the memory of the matching device. It shows that each entry is written once, in order, and that the final wrap steps the device counter. A second full stream sent while the counter does not match must leave the memory unchanged while the pointer still travels. This separates a gated store from a gated advance. Sweeps of all 128 pointer-load values and all 8 counter values, a wrap from 7 to 0, loads that coincide with nibbles, and out-of-range reads cover the clamp, modulo and priority edges.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;
  localparam int unsigned DEF_DEPTH = 80;
  localparam int unsigned DEF_DW    = 4;
  localparam int unsigned DEF_DEV_W = 3;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/disp_ptr_ctrl.sv
module disp_ptr_ctrl
  import disp_wr_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned DEV_W = DEF_DEV_W,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEV_W-1:0] dev_id_i,
  input  logic             wr_valid_i,
  input  logic             ld_ptr_i,
  input  logic [PTR_W-1:0] ptr_val_i,
  input  logic             ld_dev_i,
  input  logic [DEV_W-1:0] dev_val_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [DEV_W-1:0] dev_cnt_o,
  output logic             store_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  ptr_op_e          op;
  logic [PTR_W-1:0] ptr_q, ld_ptr_safe;
  logic [DEV_W-1:0] dev_q;

  always_comb begin
    if (ld_ptr_i || ld_dev_i) op = OP_LOAD;
    else if (wr_valid_i)      op = OP_STEP;
    else                      op = OP_IDLE;
  end

  // out-of-range load values fall back to entry 0
  assign ld_ptr_safe = (ptr_val_i > LAST) ? '0 : ptr_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      dev_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          if (ld_ptr_i) ptr_q <= ld_ptr_safe;
          if (ld_dev_i) dev_q <= dev_val_i;
        end
        OP_STEP: begin
          if (ptr_q == LAST) begin
            ptr_q <= '0;
            dev_q <= dev_q + 1'b1;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign store_o   = (op == OP_STEP) && (dev_q == dev_id_i);
  assign ptr_o     = ptr_q;
  assign dev_cnt_o = dev_q;
endmodule

// File: rtl/disp_mem.sv
module disp_mem
  import disp_wr_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned DW    = DEF_DW,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wa_i,
  input  logic [DW-1:0]    wd_i,
  input  logic [PTR_W-1:0] ra_i,
  output logic [DW-1:0]    rd_o
);
  logic [DW-1:0] cell_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           cell_q[g] <= '0;
      else if (we_i && wa_i == PTR_W'(g))    cell_q[g] <= wd_i;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ra_i == PTR_W'(i)) rd_o = cell_q[i];
  end
endmodule

// File: rtl/disp_ram_writer.sv
module disp_ram_writer
  import disp_wr_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned DW    = DEF_DW,
  parameter int unsigned DEV_W = DEF_DEV_W,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEV_W-1:0] dev_id_i,
  input  logic             wr_valid_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             ld_ptr_i,
  input  logic [PTR_W-1:0] ptr_val_i,
  input  logic             ld_dev_i,
  input  logic [DEV_W-1:0] dev_val_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [DEV_W-1:0] dev_cnt_o
);
  logic             store;
  logic [PTR_W-1:0] ptr;

  disp_ptr_ctrl #(.DEPTH(DEPTH), .DEV_W(DEV_W)) u_ptr (
    .clk_i, .rst_ni, .dev_id_i, .wr_valid_i, .ld_ptr_i, .ptr_val_i,
    .ld_dev_i, .dev_val_i, .ptr_o(ptr), .dev_cnt_o, .store_o(store)
  );

  disp_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i, .rst_ni, .we_i(store), .wa_i(ptr), .wd_i(wr_data_i),
    .ra_i(rd_addr_i), .rd_o(rd_data_o)
  );

  assign ptr_o = ptr;
endmodule

// File: rtl/disp_ram_writer_chk.sv
module disp_ram_writer_chk #(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned DW    = 4,
  parameter int unsigned DEV_W = 3,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DEV_W-1:0] dev_id_i,
  input logic             wr_valid_i,
  input logic [DW-1:0]    wr_data_i,
  input logic             ld_ptr_i,
  input logic [PTR_W-1:0] ptr_val_i,
  input logic             ld_dev_i,
  input logic [DEV_W-1:0] dev_val_i,
  input logic [PTR_W-1:0] rd_addr_i,
  input logic [DW-1:0]    rd_data_o,
  input logic [PTR_W-1:0] ptr_o,
  input logic [DEV_W-1:0] dev_cnt_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  logic step;
  assign step = wr_valid_i && !ld_ptr_i && !ld_dev_i;

  a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && ptr_o != LAST |=> ptr_o == $past(ptr_o) + 1'b1 && dev_cnt_o == $past(dev_cnt_o));

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && ptr_o == LAST |=> ptr_o == '0 && dev_cnt_o == $past(dev_cnt_o) + 1'b1);

  a_r5_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST);

  a_r6_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ptr_i |=> ptr_o == (($past(ptr_val_i) > LAST) ? '0 : $past(ptr_val_i)));

  a_r7_dev_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_dev_i |=> dev_cnt_o == $past(dev_val_i));

  a_r8_load_only_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_dev_i && !ld_ptr_i |=> $stable(ptr_o));

  a_r9_high_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i > LAST |-> rd_data_o == '0);
endmodule

bind disp_ram_writer disp_ram_writer_chk #(.DEPTH(DEPTH), .DW(DW), .DEV_W(DEV_W)) chk_i (
  .clk_i, .rst_ni, .dev_id_i, .wr_valid_i, .wr_data_i, .ld_ptr_i, .ptr_val_i,
  .ld_dev_i, .dev_val_i, .rd_addr_i, .rd_data_o, .ptr_o, .dev_cnt_o
);

// File: tb/disp_ram_writer_tb_top.sv
module disp_ram_writer_tb_top;
  localparam int DEPTH = 80;
  localparam logic [2:0] MY_ID = 3'd5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] dev_id_i = MY_ID;
  logic       wr_valid_i = 1'b0;
  logic [3:0] wr_data_i = '0;
  logic       ld_ptr_i = 1'b0;
  logic [6:0] ptr_val_i = '0;
  logic       ld_dev_i = 1'b0;
  logic [2:0] dev_val_i = '0;
  logic [6:0] rd_addr_i = '0;
  logic [3:0] rd_data_o;
  logic [6:0] ptr_o;
  logic [2:0] dev_cnt_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [3:0] m_mem [DEPTH];
  int m_ptr = 0;
  int m_dev = 0;

  always #2.5 clk_i = ~clk_i;

  disp_ram_writer dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at negedge, clock it in, sample at the next negedge; model follows R2-R8
  task automatic cyc(bit wr, int d, bit lp, int pv, bit ld, int dv);
    wr_valid_i = wr; wr_data_i = 4'(d);
    ld_ptr_i = lp; ptr_val_i = 7'(pv);
    ld_dev_i = ld; dev_val_i = 3'(dv);
    @(posedge clk_i);
    if (lp || ld) begin
      if (lp) m_ptr = (pv >= DEPTH) ? 0 : pv;
      if (ld) m_dev = dv;
    end else if (wr) begin
      if (m_dev == int'(MY_ID)) m_mem[m_ptr] = 4'(d);
      if (m_ptr == DEPTH - 1) begin m_ptr = 0; m_dev = (m_dev + 1) % 8; end
      else m_ptr++;
    end
    @(negedge clk_i);
    wr_valid_i = 0; ld_ptr_i = 0; ld_dev_i = 0;
  endtask

  task automatic chk_pos(string tag);
    chk({tag, " ptr"}, int'(ptr_o), m_ptr);
    chk({tag, " dev"}, int'(dev_cnt_o), m_dev);
  endtask

  task automatic chk_mem(string tag);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = 7'(a); #0.5;
      chk(tag, int'(rd_data_o), int'(m_mem[a]));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk_pos("R1");
    chk_mem("R1 mem");

    // R2 / R3: full matched stream, ends in wrap to next device
    cyc(0, 0, 1, 0, 1, int'(MY_ID));
    chk_pos("R7 dev load");
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, (i * 7 + 3) & 15, 0, 0, 0, 0);
      chk_pos("R2 step");
    end
    chk_mem("R2 stored");
    chk("R3 wrap ptr", int'(ptr_o), 0);
    chk("R3 wrap dev", int'(dev_cnt_o), int'(MY_ID) + 1);

    // R4: mismatched stream leaves memory untouched, still advances
    for (int i = 0; i < DEPTH + 5; i++) begin
      cyc(1, (i * 5 + 1) & 15, 0, 0, 0, 0);
      chk_pos("R4 advance");
    end
    chk_mem("R4 unchanged");

    // R3: device counter 7 wraps to 0
    cyc(0, 0, 1, 75, 1, 7);
    for (int i = 0; i < 6; i++) cyc(1, 9, 0, 0, 0, 0);
    chk("R3 mod8 dev", int'(dev_cnt_o), 0);
    chk("R3 mod8 ptr", int'(ptr_o), 1);

    // R2/R4/R7: only the matching counter value stores
    for (int v = 0; v < 8; v++) begin
      cyc(0, 0, 1, 10 + v, 1, v);
      cyc(1, v ^ 4'hA, 0, 0, 0, 0);
      chk_pos("R7 sweep");
    end
    chk_mem("R4 id sweep");

    // R6 / R5: every load value, clamp at 80+
    for (int v = 0; v < 128; v++) begin
      cyc(0, 0, 1, v, 0, 0);
      chk("R6 load", int'(ptr_o), (v >= DEPTH) ? 0 : v);
      chk("R5 range", int'(ptr_o < 7'(DEPTH)), 1);
    end

    // R8: loads win over a coincident nibble
    cyc(0, 0, 1, 20, 1, int'(MY_ID));
    cyc(1, 4'hF, 1, 30, 0, 0);
    chk_pos("R8 ptr load");
    cyc(1, 4'hE, 0, 0, 1, int'(MY_ID));
    chk_pos("R8 dev load");
    cyc(1, 4'hD, 1, 40, 1, 2);
    chk_pos("R8 both loads");
    chk_mem("R8 no store");

    // R9: reads above the top entry return 0
    for (int a = DEPTH; a < 128; a++) begin
      rd_addr_i = 7'(a); #0.5;
      chk("R9 high read", int'(rd_data_o), 0);
    end

    finish_run();
  end
endmodule